// File: doc/BRIEF.md
# Load Buffer Entry Allocator

This block hands out load buffer entries to memory-read micro-ops as they enter the out-of-order window, and takes them back as those ops retire. Each request says whether the op uses a load-address port, whether it carries a store-data part, whether it is a gather, and how many elements the gather loads. From these the block works out how many entries the op needs. A plain load needs one entry. A gather needs one entry per element. A store or a pure ALU op needs none.

Entries live in a ring of `CAPACITY` slots, which is 72 by default. They are handed out at a tail index and released in program order at a head index. When the current request needs more entries than are free, the block raises a stall towards the front end and takes nothing. A gather is therefore always granted whole or not at all. The retire logic reports each cycle how many of the oldest entries to release. A release larger than the number of occupied entries is flagged and clamped, so the free count stays within its range.

Top module: `load_slot_alloc`

## Requirements
- R1: After reset, `freeCount` equals `CAPACITY`, `allocIdx` and `oldestIdx` are 0, and `grant` and `stall` are 0 while `reqValid` is 0.
- R2: An op needs an entry exactly when `reqLoadPort`=1 and `reqStoreData`=0. Such an op with `reqGather`=0 takes exactly one entry, whatever `reqElems` holds.
- R3: A valid request needing zero entries gets `grant`=1 in the same cycle and leaves `freeCount` unchanged. This covers ops with `reqLoadPort`=0, ops with `reqStoreData`=1, and gathers with `reqElems`=0.
- R4: A gather with `reqLoadPort`=1 and `reqStoreData`=0 reserves `reqElems` entries in a single cycle. `allocIdx` shows the first reserved index while it is granted and then advances by the whole count.
- R5: When a valid request needs more entries than `freeCount` shows in that cycle, `stall`=1 and `grant`=0 in the same cycle, and no entry is taken. A release in that same cycle does not count towards the decision.
- R6: `relCount` entries are released at the clock edge. The next `freeCount` is the current value, minus the entries granted, plus the entries released. `oldestIdx` advances by the number released.
- R7: When `relCount` exceeds the occupied count (`CAPACITY` − `freeCount`), `relError`=1 in that cycle and only the occupied entries are released.
- R8: `freeCount` never exceeds `CAPACITY` and never underflows, including under over-release at an empty buffer.
- R9: Entry indices wrap modulo `CAPACITY`, so the index after `CAPACITY`−1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A micro-op is presented for allocation |
| reqLoadPort | input | 1 | The op uses a load-address port |
| reqStoreData | input | 1 | The op has a store-data component |
| reqGather | input | 1 | The op is a gather |
| reqElems | input | ELEM_W | Element count of a gather |
| relCount | input | REL_W | Number of oldest entries retiring this cycle |
| grant | output | 1 | The request is accepted this cycle |
| stall | output | 1 | Not enough free entries; the front end must hold |
| allocIdx | output | IDX_W | Index of the first entry given to the current request |
| oldestIdx | output | IDX_W | Index of the oldest occupied entry |
| freeCount | output | CNT_W | Number of free entries |
| relError | output | 1 | More entries released than are held |

## Verification
The bench drives gathers until the free count drops below the next gather's size. It then confirms that the whole gather stalls while a single load still fits. A design that allocated a gather in part would show a drop in the free count during the stall. A design that counted same-cycle releases would grant too early. The bench also offers a non-gather load with a large element count and a store that carries a gather flag; a wrong decode would take 9 or 8 entries instead of 1 or 0. The bench releases past an empty buffer, including in the same cycle as a grant. A missing clamp would push the free count above capacity or move the oldest index past the allocation index. Allocation runs past index 71, so a ring that wraps only at a power of two would report index 76 rather than 4.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic takeEn;  // entries are taken at the tail this cycle
    logic relEn;   // entries are released at the head this cycle
    logic relErr;  // release request exceeded the occupied count
  } lsaStrobes_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int CAPACITY = 72,
  parameter int MAX_ELEM = 16,
  parameter int MAX_REL  = 4,
  localparam int CNT_W  = $clog2(CAPACITY + 1),
  localparam int ELEM_W = $clog2(MAX_ELEM + 1),
  localparam int REL_W  = $clog2(MAX_REL + 1)
) (
  input  logic              reqValid,
  input  logic              reqLoadPort,
  input  logic              reqStoreData,
  input  logic              reqGather,
  input  logic [ELEM_W-1:0] reqElems,
  input  logic [REL_W-1:0]  relCount,
  input  logic [CNT_W-1:0]  freeCount,
  output logic              grant,
  output logic              stall,
  output logic [CNT_W-1:0]  takeAmt,
  output logic [CNT_W-1:0]  relAmt,
  output lsaStrobes_t       strb
);
  // Comparison width wide enough for every operand
  localparam int CMP_W = CNT_W + ELEM_W + REL_W;

  logic             needsEntry;
  logic [CMP_W-1:0] needW;
  logic [CMP_W-1:0] freeW;
  logic [CMP_W-1:0] heldW;
  logic [CMP_W-1:0] relW;

  always_comb begin
    // Port-usage rule: a load port without a store-data part means an entry
    needsEntry = reqLoadPort && !reqStoreData;
    if (!needsEntry)    needW = '0;
    else if (reqGather) needW = CMP_W'(reqElems);
    else                needW = CMP_W'(1);

    freeW = CMP_W'(freeCount);
    heldW = CMP_W'(CAPACITY) - freeW;
    relW  = CMP_W'(relCount);

    // All-or-nothing: the whole need must fit in what is free now
    stall = reqValid && (needW > freeW);
    grant = reqValid && !stall;

    strb.takeEn = grant && (needW != '0);
    strb.relErr = relW > heldW;
    relAmt      = strb.relErr ? CNT_W'(heldW) : CNT_W'(relW);
    strb.relEn  = relAmt != '0;
    takeAmt     = strb.takeEn ? CNT_W'(needW) : '0;
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int CAPACITY = 72,
  localparam int CNT_W = $clog2(CAPACITY + 1),
  localparam int IDX_W = $clog2(CAPACITY)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsaStrobes_t      strb,
  input  logic [CNT_W-1:0] takeAmt,
  input  logic [CNT_W-1:0] relAmt,
  output logic [CNT_W-1:0] freeCount,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] oldestIdx
);
  localparam bit POW2 = (CAPACITY & (CAPACITY - 1)) == 0;

  logic [CNT_W-1:0] freeQ;
  logic [CNT_W-1:0] freeNext;
  logic [IDX_W-1:0] tailQ;
  logic [IDX_W-1:0] headQ;
  logic [IDX_W-1:0] tailAdv;
  logic [IDX_W-1:0] headAdv;

  // Modular advance for a ring whose size is not a power of two
  function automatic logic [IDX_W-1:0] ringAdd(input logic [IDX_W-1:0] p,
                                               input logic [CNT_W-1:0] a);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(p) + (CNT_W+1)'(a);
    if (s >= (CNT_W+1)'(CAPACITY)) s = s - (CNT_W+1)'(CAPACITY);
    return s[IDX_W-1:0];
  endfunction

  generate
    if (POW2) begin : g_pow2Ring
      assign tailAdv = tailQ + takeAmt[IDX_W-1:0];
      assign headAdv = headQ + relAmt[IDX_W-1:0];
    end else begin : g_modRing
      assign tailAdv = ringAdd(tailQ, takeAmt);
      assign headAdv = ringAdd(headQ, relAmt);
    end
  endgenerate

  always_comb begin
    freeNext = freeQ;
    if (strb.takeEn) freeNext = freeNext - takeAmt;
    if (strb.relEn)  freeNext = freeNext + relAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeQ <= CNT_W'(CAPACITY);
      tailQ <= '0;
      headQ <= '0;
    end else begin
      freeQ <= freeNext;
      if (strb.takeEn) tailQ <= tailAdv;
      if (strb.relEn)  headQ <= headAdv;
    end
  end

  assign freeCount = freeQ;
  assign allocIdx  = tailQ;
  assign oldestIdx = headQ;
endmodule

// File: rtl/load_slot_alloc.sv
module load_slot_alloc
  import lsa_pkg::*;
#(
  parameter int CAPACITY = 72,
  parameter int MAX_ELEM = 16,
  parameter int MAX_REL  = 4,
  localparam int CNT_W  = $clog2(CAPACITY + 1),
  localparam int IDX_W  = $clog2(CAPACITY),
  localparam int ELEM_W = $clog2(MAX_ELEM + 1),
  localparam int REL_W  = $clog2(MAX_REL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqLoadPort,
  input  logic              reqStoreData,
  input  logic              reqGather,
  input  logic [ELEM_W-1:0] reqElems,
  input  logic [REL_W-1:0]  relCount,
  output logic              grant,
  output logic              stall,
  output logic [IDX_W-1:0]  allocIdx,
  output logic [IDX_W-1:0]  oldestIdx,
  output logic [CNT_W-1:0]  freeCount,
  output logic              relError
);
  lsaStrobes_t      strb;
  logic [CNT_W-1:0] takeAmt;
  logic [CNT_W-1:0] relAmt;

  lsa_ctrl #(
    .CAPACITY(CAPACITY), .MAX_ELEM(MAX_ELEM), .MAX_REL(MAX_REL)
  ) ctrl_i (
    .reqValid(reqValid), .reqLoadPort(reqLoadPort), .reqStoreData(reqStoreData),
    .reqGather(reqGather), .reqElems(reqElems), .relCount(relCount),
    .freeCount(freeCount), .grant(grant), .stall(stall),
    .takeAmt(takeAmt), .relAmt(relAmt), .strb(strb)
  );

  lsa_datapath #(.CAPACITY(CAPACITY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .takeAmt(takeAmt), .relAmt(relAmt),
    .freeCount(freeCount), .allocIdx(allocIdx), .oldestIdx(oldestIdx)
  );

  assign relError = strb.relErr;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int CAPACITY = 72,
  parameter int MAX_ELEM = 16,
  parameter int MAX_REL  = 4,
  localparam int CNT_W  = $clog2(CAPACITY + 1),
  localparam int IDX_W  = $clog2(CAPACITY),
  localparam int ELEM_W = $clog2(MAX_ELEM + 1),
  localparam int REL_W  = $clog2(MAX_REL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqLoadPort,
  input logic              reqStoreData,
  input logic              reqGather,
  input logic [ELEM_W-1:0] reqElems,
  input logic [REL_W-1:0]  relCount,
  input logic              grant,
  input logic              stall,
  input logic [IDX_W-1:0]  allocIdx,
  input logic [IDX_W-1:0]  oldestIdx,
  input logic [CNT_W-1:0]  freeCount,
  input logic              relError
);
  int span;
  int occupiedMod;
  always_comb begin
    span = (allocIdx >= oldestIdx) ? int'(allocIdx) - int'(oldestIdx)
                                   : int'(allocIdx) + CAPACITY - int'(oldestIdx);
    occupiedMod = (freeCount == '0) ? 0 : CAPACITY - int'(freeCount);
  end

  assert_free_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeCount) <= CAPACITY);

  assert_grant_stall_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && stall));

  assert_stall_takes_nothing_R5: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> freeCount >= $past(freeCount));

  assert_zero_need_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqLoadPort && !reqStoreData)) |-> grant);

  assert_zero_need_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqLoadPort && !reqStoreData) && relCount == '0) |=> $stable(freeCount));

  assert_single_load_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant && reqLoadPort && !reqStoreData && !reqGather && relCount == '0)
      |=> int'(freeCount) == int'($past(freeCount)) - 1);

  assert_gather_short_stalls_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLoadPort && !reqStoreData && reqGather && int'(reqElems) > int'(freeCount))
      |-> stall);

  assert_over_release_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    relError == (int'(relCount) > CAPACITY - int'(freeCount)));

  assert_ring_span_R6: assert property (@(posedge clk) disable iff (!rstN)
    span == occupiedMod);
endmodule

bind load_slot_alloc lsa_checker #(
  .CAPACITY(CAPACITY), .MAX_ELEM(MAX_ELEM), .MAX_REL(MAX_REL)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLoadPort(reqLoadPort),
  .reqStoreData(reqStoreData), .reqGather(reqGather), .reqElems(reqElems),
  .relCount(relCount), .grant(grant), .stall(stall), .allocIdx(allocIdx),
  .oldestIdx(oldestIdx), .freeCount(freeCount), .relError(relError)
);

// File: tb/load_slot_alloc_tb_top.sv
module load_slot_alloc_tb_top;
  localparam int CAP    = 72;
  localparam int MAXE   = 16;
  localparam int MAXR   = 4;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int IDX_W  = $clog2(CAP);
  localparam int ELEM_W = $clog2(MAXE + 1);
  localparam int REL_W  = $clog2(MAXR + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqLoadPort = 1'b0, reqStoreData = 1'b0, reqGather = 1'b0;
  logic [ELEM_W-1:0] reqElems = '0;
  logic [REL_W-1:0]  relCount = '0;
  logic grant, stall, relError;
  logic [IDX_W-1:0] allocIdx, oldestIdx;
  logic [CNT_W-1:0] freeCount;

  int checks = 0;
  int errors = 0;
  int mFree = CAP, mTail = 0, mHead = 0;

  always #2 clk = ~clk;

  load_slot_alloc #(.CAPACITY(CAP), .MAX_ELEM(MAXE), .MAX_REL(MAXR)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLoadPort(reqLoadPort),
    .reqStoreData(reqStoreData), .reqGather(reqGather), .reqElems(reqElems),
    .relCount(relCount), .grant(grant), .stall(stall), .allocIdx(allocIdx),
    .oldestIdx(oldestIdx), .freeCount(freeCount), .relError(relError)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, check same-cycle outputs, then registered outputs
  task automatic step(input bit v, input bit lp, input bit sd, input bit g,
                      input int elems, input int rel, input string tag);
    int need, held, applied;
    bit expGrant, expErr;
    @(negedge clk);
    reqValid = v; reqLoadPort = lp; reqStoreData = sd; reqGather = g;
    reqElems = ELEM_W'(elems); relCount = REL_W'(rel);
    need = (lp && !sd) ? (g ? elems : 1) : 0;
    expGrant = v && (need <= mFree);
    held = CAP - mFree;
    expErr = rel > held;
    applied = expErr ? held : rel;
    #1;
    chk(tag, "grant", int'(grant), int'(expGrant));
    chk(tag, "stall", int'(stall), int'(v && !expGrant));
    chk(tag, "relError", int'(relError), int'(expErr));
    if (expGrant) chk(tag, "allocIdx", int'(allocIdx), mTail);
    if (expGrant) begin
      mFree -= need;
      mTail = (mTail + need) % CAP;
    end
    mFree += applied;
    mHead = (mHead + applied) % CAP;
    @(posedge clk);
    #1;
    chk(tag, "freeCount", int'(freeCount), mFree);
    chk(tag, "oldestIdx", int'(oldestIdx), mHead);
    chk(tag, "allocIdx next", int'(allocIdx), mTail);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; reqLoadPort = 0; reqStoreData = 0; reqGather = 0;
    reqElems = '0; relCount = '0;
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R1", "freeCount", int'(freeCount), CAP);
    chk("R1", "allocIdx", int'(allocIdx), 0);
    chk("R1", "oldestIdx", int'(oldestIdx), 0);
    chk("R1", "stall", int'(stall), 0);
    chk("R1", "grant", int'(grant), 0);
  endtask

  task automatic t_singleLoads();
    step(1, 1, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 9, 0, "R2");   // element count ignored without gather flag
    chk("R2", "freeCount after four loads", int'(freeCount), 68);
    chk("R2", "allocIdx after four loads", int'(allocIdx), 4);
  endtask

  task automatic t_zeroNeed();
    step(1, 1, 1, 1, 8, 0, "R3");   // store-data part present
    step(1, 0, 0, 0, 0, 0, "R3");   // pure ALU op
    step(1, 0, 0, 1, 5, 0, "R3");   // no load port
    step(1, 1, 0, 1, 0, 0, "R3");   // gather of zero elements
    chk("R3", "freeCount unchanged", int'(freeCount), 68);
  endtask

  task automatic t_gather();
    step(1, 1, 0, 1, 8, 0, "R4");
    chk("R4", "freeCount after gather 8", int'(freeCount), 60);
    chk("R4", "allocIdx after gather 8", int'(allocIdx), 12);
  endtask

  task automatic t_stall();
    step(1, 1, 0, 1, 16, 0, "R4");
    step(1, 1, 0, 1, 16, 0, "R4");
    step(1, 1, 0, 1, 16, 0, "R4");
    chk("R5", "freeCount before short gather", int'(freeCount), 12);
    step(1, 1, 0, 1, 16, 0, "R5");  // 16 > 12: whole gather held back
    chk("R5", "no partial take", int'(freeCount), 12);
    step(1, 1, 0, 1, 16, 4, "R5");  // same-cycle release does not help
    chk("R5", "release visible next cycle", int'(freeCount), 16);
    step(1, 1, 0, 1, 16, 0, "R9");  // fits now; tail crosses index 71
    chk("R9", "allocIdx wrapped", int'(allocIdx), 4);
    chk("R8", "freeCount empty", int'(freeCount), 0);
    step(1, 1, 0, 0, 0, 0, "R5");   // single load at zero free stalls
    step(1, 1, 1, 0, 0, 0, "R3");   // store still passes at zero free
  endtask

  task automatic t_release();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 4, "R6");
    chk("R6", "freeCount after releases", int'(freeCount), 12);
    chk("R6", "oldestIdx after releases", int'(oldestIdx), 16);
  endtask

  task automatic t_overRelease();
    for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 4, "R6");
    step(0, 0, 0, 0, 0, 3, "R6");
    chk("R6", "one entry held", int'(freeCount), CAP - 1);
    step(1, 1, 0, 1, 2, 4, "R7");   // grant 2 while over-releasing
    chk("R7", "clamped with take", int'(freeCount), CAP - 2);
    step(0, 0, 0, 0, 0, 4, "R7");
    chk("R7", "clamped to held", int'(freeCount), CAP);
    chk("R7", "head meets tail", int'(oldestIdx), int'(allocIdx));
    step(0, 0, 0, 0, 0, 1, "R8");   // release at empty
    chk("R8", "no overflow", int'(freeCount), CAP);
  endtask

  initial begin
    t_reset();
    t_singleLoads();
    t_zeroNeed();
    t_gather();
    t_stall();
    t_release();
    t_overRelease();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule